// File: doc/BRIEF.md
# Flow-Controlled Serial Receiver

This block receives asynchronous serial characters with eight data bits, no parity and one stop bit, least significant bit first. The receive line is sampled once per clock, with the clock running at OVERSAMPLE times the bit rate. Each completed character is pushed, together with a framing-error bit, into a two-entry receive queue. The host pops the queue with a single-cycle read strobe and sees the oldest entry, an empty flag and a full flag.

When flow control is enabled, the receiver raises a request-to-send style output (`rts`, active high meaning "pause") late in the stop bit of any character that leaves the queue full. A remote transmitter that misses this signal may still send one more character. That character is held in a spare register beside the queue and is moved into the queue in the same cycle a read frees a slot. A character that arrives while both the queue and the spare register are occupied is discarded, and an overrun flag is raised.

Top module: `uart_rx_rts`

## Requirements
- R1: After synchronous reset, `fifoEmpty` is 1 and `fifoFull`, `rts` and `overrun` are all 0.
- R2: An 8N1 frame on `rxd` with a high stop bit appears at `rdData`, with bit 0 being the first data bit received, and `fifoEmpty` falls. Each bit is sampled near its middle.
- R3: A low pulse on `rxd` that is shorter than half a bit period is rejected as a start bit, and no character is queued.
- R4: The queue holds two characters and delivers them oldest first. `fifoFull` is 1 when both slots are used. A read strobe while `fifoEmpty` is 1 changes no state.
- R5: A character that completes while the queue is full is kept in the spare register. It enters the queue in the same cycle a read frees a slot, so `fifoFull` stays 1 across that read, and it is later delivered in order.
- R6: A character that completes while the queue is full and the spare register is occupied is discarded and sets `overrun`. The next successful read clears `overrun`.
- R7: A stop bit sampled low sets `rdFrameErr` to 1 for that character only. A high stop bit gives `rdFrameErr` = 0.
- R8: With `rtsEnable` = 1, `rts` rises about two-thirds of the way into the stop bit of a character that leaves the queue full. It is still low at mid-stop and is high before the stop bit ends.
- R9: With `rtsEnable` = 0, `rts` is 0 at all times, including when the queue is full.
- R10: With `rts` high, a read that pops the queue lowers `rts` on the next clock, unless a full-queue stop point falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, OVERSAMPLE times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| rxd | input | 1 | Serial receive line, idle high |
| rtsEnable | input | 1 | Enables flow control on `rts` |
| rdStrobe | input | 1 | Single-cycle pop of the oldest queued character |
| rdData | output | DATA_BITS | Oldest queued character |
| rdFrameErr | output | 1 | Framing-error bit stored with `rdData` |
| fifoEmpty | output | 1 | Queue holds no characters |
| fifoFull | output | 1 | Queue holds FIFO_DEPTH characters |
| overrun | output | 1 | A character was discarded; cleared by a read |
| rts | output | 1 | High asks the remote transmitter to pause |

## Verification
The case that needs the most care is a host read that lands while a character is waiting in the spare register. In that single cycle the pop, the move from the spare register into the queue and the lowering of `rts` all take place together. The bench fills the queue, lets a late character arrive into the spare register, and then reads. It checks that `fifoFull` stays high, that `rts` drops one clock later, and that all three characters come out in arrival order. The same full-queue state is pushed one character further to check that the overrun character is dropped and the flag is cleared by the next read.

// File: rtl/uart_rx_rts_pkg.sv
package uart_rx_rts_pkg;
  // Timing strobes from the receive sequencer to the datapath
  typedef struct packed {
    logic shiftEn;   // mid-bit sample of a data bit
    logic charDone;  // mid-stop sample: character complete
    logic stopBad;   // stop bit sampled low (valid with charDone)
    logic rtsPoint;  // two-thirds point of the stop bit
  } rxStrobes_t;
endpackage

// File: rtl/uart_rx_rts_ctrl.sv
module uart_rx_rts_ctrl
  import uart_rx_rts_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxSync,
  output rxStrobes_t strobes
);
  localparam int MID_TICK  = OVERSAMPLE / 2 - 1;
  localparam int TAIL      = (2 * OVERSAMPLE) / 3 - OVERSAMPLE / 2;
  localparam int STOP_END  = OVERSAMPLE - 1 + TAIL;
  localparam int CNT_W     = $clog2(STOP_END + 1);
  localparam int BIT_W     = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(MID_TICK);
  localparam logic [CNT_W-1:0] CNT_BIT  = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] CNT_STOP = CNT_W'(STOP_END);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);

  typedef enum logic [1:0] {IDLE, START, DATA, STOP} rxState_t;

  rxState_t          state;
  logic [CNT_W-1:0]  tickCnt;
  logic [BIT_W-1:0]  bitIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      case (state)
        IDLE: begin
          tickCnt <= '0;
          if (!rxSync) state <= START;
        end
        START: begin
          if (tickCnt == CNT_MID) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            state   <= rxSync ? IDLE : DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        DATA: begin
          if (tickCnt == CNT_BIT) begin
            tickCnt <= '0;
            if (bitIdx == BIT_LAST) state <= STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        STOP: begin
          if (tickCnt == CNT_STOP) begin
            tickCnt <= '0;
            state   <= IDLE;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.shiftEn  = (state == DATA) && (tickCnt == CNT_BIT);
    strobes.charDone = (state == STOP) && (tickCnt == CNT_BIT);
    strobes.stopBad  = strobes.charDone && !rxSync;
    strobes.rtsPoint = (state == STOP) && (tickCnt == CNT_STOP);
  end
endmodule

// File: rtl/uart_rx_rts_dp.sv
module uart_rx_rts_dp
  import uart_rx_rts_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int FIFO_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rxSync,
  input  rxStrobes_t           strobes,
  input  logic                 rtsEnable,
  input  logic                 rdStrobe,
  output logic [DATA_BITS-1:0] rdData,
  output logic                 rdFrameErr,
  output logic                 fifoEmpty,
  output logic                 fifoFull,
  output logic                 overrun,
  output logic                 rts
);
  localparam int ENTRY_W = DATA_BITS + 1;
  localparam int PTR_W   = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int OCC_W   = $clog2(FIFO_DEPTH + 1);
  localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(FIFO_DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(FIFO_DEPTH - 1);

  logic [DATA_BITS-1:0] shiftReg;
  logic [ENTRY_W-1:0]   mem [FIFO_DEPTH];
  logic [PTR_W-1:0]     rdPtr, wrPtr;
  logic [OCC_W-1:0]     occ, occNext;
  logic [ENTRY_W-1:0]   holdData, newChar, pushData;
  logic                 holdValid, holdSet, holdClr;
  logic                 pop, push, space, dropChar, rtsReg;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  // Data bits arrive LSB first: shift in at the top
  always_ff @(posedge clk) begin
    if (rst) shiftReg <= '0;
    else if (strobes.shiftEn) shiftReg <= {rxSync, shiftReg[DATA_BITS-1:1]};
  end

  assign newChar = {strobes.stopBad, shiftReg};
  assign pop     = rdStrobe && (occ != '0);
  assign space   = (occ != OCC_FULL) || pop;

  // Spare register drains first; new character goes to queue or spare
  always_comb begin
    push     = 1'b0;
    pushData = holdData;
    holdSet  = 1'b0;
    holdClr  = 1'b0;
    dropChar = 1'b0;
    if (holdValid) begin
      if (space) begin
        push    = 1'b1;
        holdSet = strobes.charDone;
        holdClr = !strobes.charDone;
      end else if (strobes.charDone) begin
        dropChar = 1'b1;
      end
    end else if (strobes.charDone) begin
      pushData = newChar;
      if (space) push = 1'b1;
      else holdSet = 1'b1;
    end
  end

  assign occNext = occ + OCC_W'(push) - OCC_W'(pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < FIFO_DEPTH; i++) mem[i] <= '0;
      rdPtr <= '0;
      wrPtr <= '0;
      occ   <= '0;
    end else begin
      if (push) begin
        mem[wrPtr] <= pushData;
        wrPtr      <= nextPtr(wrPtr);
      end
      if (pop) rdPtr <= nextPtr(rdPtr);
      occ <= occNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdValid <= 1'b0;
      holdData  <= '0;
    end else if (holdSet) begin
      holdValid <= 1'b1;
      holdData  <= newChar;
    end else if (holdClr) begin
      holdValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) overrun <= 1'b0;
    else if (dropChar) overrun <= 1'b1;
    else if (pop) overrun <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || !rtsEnable) rtsReg <= 1'b0;
    else if (strobes.rtsPoint && (occNext == OCC_FULL)) rtsReg <= 1'b1;
    else if (pop) rtsReg <= 1'b0;
  end

  assign rts        = rtsReg && rtsEnable;
  assign rdData     = mem[rdPtr][DATA_BITS-1:0];
  assign rdFrameErr = mem[rdPtr][DATA_BITS];
  assign fifoEmpty  = (occ == '0);
  assign fifoFull   = (occ == OCC_FULL);
endmodule

// File: rtl/uart_rx_rts.sv
module uart_rx_rts
  import uart_rx_rts_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_BITS   = 8,
  parameter int FIFO_DEPTH  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rxd,
  input  logic                 rtsEnable,
  input  logic                 rdStrobe,
  output logic [DATA_BITS-1:0] rdData,
  output logic                 rdFrameErr,
  output logic                 fifoEmpty,
  output logic                 fifoFull,
  output logic                 overrun,
  output logic                 rts
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rxSync;
  rxStrobes_t             strobes;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '1;
        else syncQ <= rxd;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '1;
        else syncQ <= {syncQ[SYNC_STAGES-2:0], rxd};
      end
    end
  endgenerate

  assign rxSync = syncQ[SYNC_STAGES-1];

  uart_rx_rts_ctrl #(
    .OVERSAMPLE(OVERSAMPLE),
    .DATA_BITS (DATA_BITS)
  ) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .rxSync (rxSync),
    .strobes(strobes)
  );

  uart_rx_rts_dp #(
    .DATA_BITS (DATA_BITS),
    .FIFO_DEPTH(FIFO_DEPTH)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .rxSync    (rxSync),
    .strobes   (strobes),
    .rtsEnable (rtsEnable),
    .rdStrobe  (rdStrobe),
    .rdData    (rdData),
    .rdFrameErr(rdFrameErr),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .overrun   (overrun),
    .rts       (rts)
  );
endmodule

// File: rtl/uart_rx_rts_chk.sv
module uart_rx_rts_chk (
  input logic clk,
  input logic rst,
  input logic rtsEnable,
  input logic rdStrobe,
  input logic fifoEmpty,
  input logic fifoFull,
  input logic overrun,
  input logic rts
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (fifoEmpty && !fifoFull && !rts && !overrun));

  // R4
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(fifoEmpty && fifoFull));

  // R9
  rts_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !rtsEnable |-> !rts);

  // R8
  rts_rise_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rts) |-> fifoFull);

  // R6
  overrun_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> fifoFull);

  // R10
  rts_read_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (rts && rdStrobe && !fifoEmpty) |=> (!rts || fifoFull));
endmodule

bind uart_rx_rts uart_rx_rts_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .rtsEnable(rtsEnable),
  .rdStrobe (rdStrobe),
  .fifoEmpty(fifoEmpty),
  .fifoFull (fifoFull),
  .overrun  (overrun),
  .rts      (rts)
);

// File: tb/uart_rx_rts_test.sv
module uart_rx_rts_test;
  localparam int CLK_PERIOD = 10;
  localparam int OS         = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic       rtsEnable = 1'b0;
  logic       rdStrobe = 1'b0;
  logic [7:0] rdData;
  logic       rdFrameErr, fifoEmpty, fifoFull, overrun, rts;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_rts uut (
    .clk(clk), .rst(rst), .rxd(rxd), .rtsEnable(rtsEnable), .rdStrobe(rdStrobe),
    .rdData(rdData), .rdFrameErr(rdFrameErr), .fifoEmpty(fifoEmpty),
    .fifoFull(fifoFull), .overrun(overrun), .rts(rts)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    rxd = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    rxd = b;
    repeat (OS) @(negedge clk);
  endtask

  task automatic sendChar(input logic [7:0] d, input logic stopVal);
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(d[i]);
    sendBit(stopVal);
    rxd = 1'b1;
  endtask

  task automatic readExpect(input string req, input logic [7:0] d, input logic fe);
    check(req, "not empty before read", fifoEmpty, 0);
    check(req, "rdData", rdData, d);
    check(req, "rdFrameErr", rdFrameErr, fe);
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic tReset();
    check("R1", "fifoEmpty", fifoEmpty, 1);
    check("R1", "fifoFull", fifoFull, 0);
    check("R1", "rts", rts, 0);
    check("R1", "overrun", overrun, 0);
  endtask

  task automatic tBasic();
    sendChar(8'hA5, 1'b1); idle(4);
    readExpect("R2", 8'hA5, 1'b0);
    sendChar(8'h3C, 1'b1); idle(4);
    readExpect("R2", 8'h3C, 1'b0);
    check("R2", "empty after reads", fifoEmpty, 1);
  endtask

  task automatic tGlitch();
    rxd = 1'b0;
    repeat (5) @(negedge clk);
    idle(40);
    check("R3", "glitch queued nothing", fifoEmpty, 1);
  endtask

  task automatic tEmptyRead();
    rdStrobe = 1'b1; @(negedge clk); rdStrobe = 1'b0; @(negedge clk);
    check("R4", "empty read keeps empty", fifoEmpty, 1);
    sendChar(8'h81, 1'b1); idle(4);
    check("R4", "one entry not full", fifoFull, 0);
    sendChar(8'h7E, 1'b1); idle(4);
    check("R4", "two entries full", fifoFull, 1);
    readExpect("R4", 8'h81, 1'b0);
    readExpect("R4", 8'h7E, 1'b0);
    check("R4", "empty after two reads", fifoEmpty, 1);
  endtask

  task automatic tRtsTiming();
    rtsEnable = 1'b1;
    sendChar(8'h11, 1'b1); idle(4);
    check("R8", "rts low with one entry", rts, 0);
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(8'h22 >> i);
    rxd = 1'b1;
    repeat (8) @(negedge clk);
    check("R8", "rts low at mid-stop", rts, 0);
    repeat (6) @(negedge clk);
    check("R8", "rts high late in stop", rts, 1);
    idle(6);
    check("R4", "full after two", fifoFull, 1);
    sendChar(8'h33, 1'b1); idle(4);
    check("R5", "still full with late char", fifoFull, 1);
    check("R5", "rts still high", rts, 1);
    check("R6", "no overrun for one late char", overrun, 0);
    readExpect("R5", 8'h11, 1'b0);
    check("R10", "rts drops after read", rts, 0);
    check("R5", "late char moved in, full", fifoFull, 1);
    readExpect("R5", 8'h22, 1'b0);
    readExpect("R5", 8'h33, 1'b0);
    check("R5", "empty after three", fifoEmpty, 1);
    rtsEnable = 1'b0;
  endtask

  task automatic tOverrun();
    sendChar(8'h01, 1'b1); idle(2);
    sendChar(8'h02, 1'b1); idle(2);
    check("R9", "rts low with full queue", rts, 0);
    sendChar(8'h03, 1'b1); idle(2);
    check("R6", "no overrun yet", overrun, 0);
    sendChar(8'h04, 1'b1); idle(4);
    check("R6", "overrun set", overrun, 1);
    check("R9", "rts low while disabled", rts, 0);
    readExpect("R6", 8'h01, 1'b0);
    check("R6", "overrun cleared by read", overrun, 0);
    readExpect("R6", 8'h02, 1'b0);
    readExpect("R6", 8'h03, 1'b0);
    check("R6", "fourth char dropped", fifoEmpty, 1);
  endtask

  task automatic tFrame();
    sendChar(8'h5A, 1'b0); idle(40);
    readExpect("R7", 8'h5A, 1'b1);
    sendChar(8'h5B, 1'b1); idle(4);
    readExpect("R7", 8'h5B, 1'b0);
    check("R7", "empty after frame test", fifoEmpty, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tReset();
    idle(20);
    tBasic();
    tGlitch();
    tEmptyRead();
    tRtsTiming();
    tOverrun();
    tFrame();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end
endmodule